// File: doc/BRIEF.md
# Cascadable Serial Bitstream Store

This block holds a configuration bitstream in an internal bit array and hands it out one bit at a time on a single data line. An address counter selects the current bit. While the chip enable is high and the shared output-enable/reset pin is inactive, the bit at the current address is driven straight away. Each rising clock edge then moves the counter on by one. A parameter sets the active level of the shared pin, so the block can sit behind a target that drives either polarity.

Several copies form a chain. All clocks are tied together, all data lines are tied together, and the cascade output of one copy drives the chip enable of the next. When the last address has been delivered, the next edge moves the block into its finished state. In that state it stops driving data, raises the cascade output and stays put until a reset. The next device in the chain then presents its own first bit in the same cycle. The bit array is filled through a plain write port used only by the testbench.

The sequencer has two states. `SB_RUN` delivers bits and `SB_DONE` holds after the terminal count. Five transitions are named:
- T_ADVANCE: `SB_RUN` stays in `SB_RUN` and increments the counter, enabled, below the terminal count.
- T_HOLD: `SB_RUN` stays in `SB_RUN` with the counter frozen, chip enable low.
- T_FINISH: `SB_RUN` goes to `SB_DONE`, enabled, at the terminal count.
- T_PARKED: `SB_DONE` stays in `SB_DONE`.
- T_CLEAR: any state goes to `SB_RUN` with the counter at zero while reset is active.

Top module: `serial_bit_store`

## Requirements
- R1: While reset is active, the counter is zero, `data_drive` is 0 (data high-impedance) and `cascade_out` is 0, whatever the chip enable.
- R2: With `RST_HIGH`=1, reset is active when `oe_rst` is 1. With `RST_HIGH`=0, reset is active when `oe_rst` is 0.
- R3: Once reset is inactive and `chip_en` is 1, the bit at address 0 is driven on `data_out` before any rising clock edge.
- R4: On each rising edge with `chip_en`=1, out of reset and below the terminal count, the counter goes up by one. `data_out` then carries the bit at the new address.
- R5: While `chip_en` is 0, the counter holds its value and `data_drive` is 0.
- R6: The terminal count is `DEPTH`-1. A rising edge with `chip_en`=1 at that count enters the finished state. In that state `data_drive` is 0 and the counter no longer advances until the next reset.
- R7: `cascade_out` is 1 exactly when the block is finished and `chip_en` is 1, and never while `data_drive` is 1. In a chain, the next device drives its address-0 bit in the same cycle.
- R8: A write with `wr_en`=1 stores `wr_bit` at `wr_addr` on the rising edge, and that value is later delivered at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, rising edge active |
| chip_en | input | 1 | Chip enable, high active |
| oe_rst | input | 1 | Shared output-enable/reset pin; active level set by `RST_HIGH` |
| wr_en | input | 1 | Array write strobe (test loading only) |
| wr_addr | input | AW | Array write address, AW = clog2(DEPTH) |
| wr_bit | input | 1 | Array write data |
| data_out | output | 1 | Serial data, high-impedance when not driving |
| data_drive | output | 1 | High when `data_out` is actively driven |
| cascade_out | output | 1 | Enable for the next device in a chain |

## Verification
The delivery path is exercised with a pattern of enable pulses in which runs of held cycles sit between runs of advancing cycles. A counter that moves while disabled, or skips a step, shows up as the wrong stored bit at the next enabled cycle. A full run to the terminal count on two chained instances separates an off-by-one terminal count from a correct hand-off: exactly one device must drive at every step, and the second must start at its own address 0. A separate instance with the opposite reset polarity, a reset in the middle of a run, and an overwrite of address 0 tell apart a fixed polarity, a counter that fails to clear and a write port that is ignored.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [0:0] {
        SB_RUN  = 1'b0,
        SB_DONE = 1'b1
    } sbs_state_e;

endpackage

// File: rtl/sbs_seq.sv
module sbs_seq
    import sbs_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_act,
    input  logic          chip_en,
    output logic [AW-1:0] bit_addr,
    output logic          done_q
);

    localparam logic [AW-1:0] TERM = AW'(DEPTH - 1);

    sbs_state_e    state_q, state_d;
    logic [AW-1:0] addr_q, addr_d;

    // state register (T_CLEAR on reset)
    always_ff @(posedge clk or posedge rst_act) begin
        if (rst_act) begin
            state_q <= SB_RUN;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (state_q)
            SB_RUN: begin
                if (chip_en) begin
                    if (addr_q == TERM) begin
                        state_d = SB_DONE;            // T_FINISH
                    end else begin
                        addr_d = addr_q + 1'b1;       // T_ADVANCE
                    end
                end
                // else T_HOLD
            end
            SB_DONE: begin
                state_d = SB_DONE;                    // T_PARKED
            end
        endcase
    end

    // outputs
    always_comb begin
        bit_addr = addr_q;
        done_q   = (state_q == SB_DONE);
    end

endmodule

// File: rtl/sbs_bit_array.sv
module sbs_bit_array #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);

    logic [DEPTH-1:0] cells;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_bit;
        end
    end

    assign rd_bit = cells[rd_addr];

endmodule

// File: rtl/sbs_out_ctl.sv
module sbs_out_ctl (
    input  logic rst_act,
    input  logic chip_en,
    input  logic done_q,
    input  logic rd_bit,
    output logic drive,
    output logic value,
    output logic cascade
);

    always_comb begin
        drive   = 1'b0;
        cascade = 1'b0;
        value   = rd_bit;
        if (!rst_act && chip_en) begin
            if (done_q) begin
                cascade = 1'b1;
            end else begin
                drive = 1'b1;
            end
        end
    end

endmodule

// File: rtl/serial_bit_store.sv
module serial_bit_store #(
    parameter int DEPTH    = 256,
    parameter bit RST_HIGH = 1'b0,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          chip_en,
    input  logic          oe_rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    output logic          data_out,
    output logic          data_drive,
    output logic          cascade_out
);

    logic          rst_act;
    logic [AW-1:0] bit_addr;
    logic          done_q;
    logic          rd_bit;
    logic          data_val;

    generate
        if (RST_HIGH) begin : g_rst_hi
            assign rst_act = oe_rst;
        end else begin : g_rst_lo
            assign rst_act = ~oe_rst;
        end
    endgenerate

    sbs_seq #(.DEPTH(DEPTH)) u_seq (
        .clk      (clk),
        .rst_act  (rst_act),
        .chip_en  (chip_en),
        .bit_addr (bit_addr),
        .done_q   (done_q)
    );

    sbs_bit_array #(.DEPTH(DEPTH)) u_arr (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_bit  (wr_bit),
        .rd_addr (bit_addr),
        .rd_bit  (rd_bit)
    );

    sbs_out_ctl u_out (
        .rst_act (rst_act),
        .chip_en (chip_en),
        .done_q  (done_q),
        .rd_bit  (rd_bit),
        .drive   (data_drive),
        .value   (data_val),
        .cascade (cascade_out)
    );

    assign data_out = data_drive ? data_val : 1'bz;

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_act,
    input logic          chip_en,
    input logic          data_drive,
    input logic          cascade_out,
    input logic          done_q,
    input logic [AW-1:0] bit_addr
);

    localparam logic [AW-1:0] TERM = AW'(DEPTH - 1);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst_act |-> (!data_drive && !cascade_out && bit_addr == '0));

    a_r3_drive_when_live: assert property (@(posedge clk) disable iff (rst_act)
        (chip_en && !done_q) |-> data_drive);

    a_r4_step_one: assert property (@(posedge clk) disable iff (rst_act)
        (chip_en && !done_q && bit_addr != TERM) |=> (bit_addr == AW'($past(bit_addr) + 1'b1)));

    a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst_act)
        !chip_en |=> ($stable(bit_addr) && !$past(data_drive)));

    a_r6_finish: assert property (@(posedge clk) disable iff (rst_act)
        (chip_en && !done_q && bit_addr == TERM) |=> done_q);

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst_act)
        done_q |=> (done_q && $stable(bit_addr)));

    a_r7_exclusive: assert property (@(posedge clk)
        !(cascade_out && data_drive));

endmodule

bind serial_bit_store sbs_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_serial_bit_store.sv
module sim_serial_bit_store;

    localparam int D0 = 16;
    localparam int D2 = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic oe_n = 1'b0;
    logic rst_hi = 1'b1;
    logic ce0 = 1'b0;
    logic ce2 = 1'b0;
    logic wr0_en = 1'b0, wr1_en = 1'b0, wr2_en = 1'b0;
    logic [3:0] wr0_addr = '0, wr1_addr = '0;
    logic [2:0] wr2_addr = '0;
    logic wr0_bit = 1'b0, wr1_bit = 1'b0, wr2_bit = 1'b0;

    logic d0, dr0, cas0, d1, dr1, cas1, d2, dr2, cas2;

    serial_bit_store #(.DEPTH(D0), .RST_HIGH(1'b0)) u0 (
        .clk(clk), .chip_en(ce0), .oe_rst(oe_n), .wr_en(wr0_en), .wr_addr(wr0_addr),
        .wr_bit(wr0_bit), .data_out(d0), .data_drive(dr0), .cascade_out(cas0));

    serial_bit_store #(.DEPTH(D0), .RST_HIGH(1'b0)) u1 (
        .clk(clk), .chip_en(cas0), .oe_rst(oe_n), .wr_en(wr1_en), .wr_addr(wr1_addr),
        .wr_bit(wr1_bit), .data_out(d1), .data_drive(dr1), .cascade_out(cas1));

    serial_bit_store #(.DEPTH(D2), .RST_HIGH(1'b1)) u2 (
        .clk(clk), .chip_en(ce2), .oe_rst(rst_hi), .wr_en(wr2_en), .wr_addr(wr2_addr),
        .wr_bit(wr2_bit), .data_out(d2), .data_drive(dr2), .cascade_out(cas2));

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    function automatic logic pat(int dev, int a);
        return logic'((((a * 5) + (dev * 3) + (a >> 2)) >> 1) & 1);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic expect_drive(input logic dr, input logic d, input logic exp, input string tag);
        check(dr === 1'b1, {tag, " drive"}, int'(dr), 1);
        if (dr === 1'b1) check(d === exp, {tag, " data"}, int'(d), int'(exp));
    endtask

    // stimulus table: {chip_en, expected address after the edge}
    localparam logic [4:0] VEC [8] = '{
        {1'b1, 4'd1}, {1'b1, 4'd2}, {1'b0, 4'd2}, {1'b0, 4'd2},
        {1'b1, 4'd3}, {1'b1, 4'd4}, {1'b0, 4'd4}, {1'b1, 4'd5}
    };

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #2;
        // R8: load arrays through the write port
        for (int a = 0; a < D0; a++) begin
            wr0_en = 1'b1; wr0_addr = 4'(a); wr0_bit = pat(0, a);
            wr1_en = 1'b1; wr1_addr = 4'(a); wr1_bit = pat(1, a);
            if (a < D2) begin
                wr2_en = 1'b1; wr2_addr = 3'(a); wr2_bit = pat(2, a);
            end else begin
                wr2_en = 1'b0;
            end
            step();
        end
        wr0_en = 1'b0; wr1_en = 1'b0; wr2_en = 1'b0;

        // R1: reset quiet even with chip enabled
        ce0 = 1'b1;
        step();
        check(dr0 === 1'b0, "R1 u0 drive in reset", int'(dr0), 0);
        check(cas0 === 1'b0, "R1 u0 cascade in reset", int'(cas0), 0);
        check(dr1 === 1'b0, "R1 u1 drive in reset", int'(dr1), 0);

        // R3: address 0 visible before any edge
        oe_n = 1'b1;
        #1;
        expect_drive(dr0, d0, pat(0, 0), "R3 u0 addr0");

        // R4/R5: table of enable patterns
        for (int i = 0; i < 8; i++) begin
            ce0 = VEC[i][4];
            step();
            if (VEC[i][4]) begin
                expect_drive(dr0, d0, pat(0, int'(VEC[i][3:0])), $sformatf("R4 vec%0d", i));
            end else begin
                check(dr0 === 1'b0, $sformatf("R5 vec%0d drive", i), int'(dr0), 0);
            end
        end

        // R4: run up to the terminal count
        ce0 = 1'b1;
        for (int a = 6; a < D0; a++) begin
            step();
            expect_drive(dr0, d0, pat(0, a), $sformatf("R4 addr%0d", a));
            check(cas0 === 1'b0, "R6 no early cascade", int'(cas0), 0);
        end

        // R6/R7: finish and hand-off
        step();
        check(dr0 === 1'b0, "R6 u0 released", int'(dr0), 0);
        check(cas0 === 1'b1, "R7 cascade raised", int'(cas0), 1);
        expect_drive(dr1, d1, pat(1, 0), "R7 u1 addr0");
        for (int k = 1; k <= 3; k++) begin
            step();
            check(dr0 === 1'b0 && cas0 === 1'b1, "R6 u0 parked", int'(dr0), 0);
            expect_drive(dr1, d1, pat(1, k), $sformatf("R7 u1 addr%0d", k));
        end
        ce0 = 1'b0;
        #1;
        check(cas0 === 1'b0, "R7 cascade follows chip_en", int'(cas0), 0);
        check(dr1 === 1'b0, "R7 u1 deselected", int'(dr1), 0);

        // R1: mid-run reset clears counter
        step();
        oe_n = 1'b0;
        step();
        oe_n = 1'b1; ce0 = 1'b1;
        #1;
        expect_drive(dr0, d0, pat(0, 0), "R1 counter cleared");
        step();
        expect_drive(dr0, d0, pat(0, 1), "R4 after reset");

        // R8: overwrite address 0
        ce0 = 1'b0;
        wr0_en = 1'b1; wr0_addr = 4'd0; wr0_bit = ~pat(0, 0);
        step();
        wr0_en = 1'b0;
        oe_n = 1'b0;
        step();
        oe_n = 1'b1; ce0 = 1'b1;
        #1;
        expect_drive(dr0, d0, ~pat(0, 0), "R8 overwrite");

        // R2: opposite polarity instance
        ce2 = 1'b1;
        #1;
        check(dr2 === 1'b0, "R2 high-level reset holds", int'(dr2), 0);
        rst_hi = 1'b0;
        #1;
        expect_drive(dr2, d2, pat(2, 0), "R2 released low");
        step();
        expect_drive(dr2, d2, pat(2, 1), "R2 advancing");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule